// File: doc/BRIEF.md
# PHY Management Register Block with Interrupt

This block is the management side of a 10/100 Ethernet PHY. A station manager reaches it over a two-wire MDIO serial link clocked by MDC, using standard Clause 22 frames. The block answers only frames whose PHY address matches five strap inputs. It holds fourteen 16-bit management registers. Two of these are read-only identifier words. One is a combined interrupt register. One is a control register whose bit 9 sets the polarity of the interrupt pin. The rest are plain storage.

The PHY core reports events as single-cycle pulses on an 8-bit event bus, for example a link change. Each pulse latches a condition flag. A per-event enable byte decides which flags may drive the interrupt pin. The enables and the flags share one register, and reading that register clears the flags. MDC and MDIO are sampled with the system clock through synchronisers. MDC must therefore toggle no faster than once every four system clocks.

Top module: `phy_mgmt_regs`

## Requirements
- R1: The block acts only on frames whose 5-bit PHY address field equals `phy_addr_strap`. A frame with any other address neither drives MDIO nor changes any register.
- R2: Frames are 32 preamble ones, start 01, opcode (10 = read, 01 = write), 5-bit PHY address, 5-bit register address, two turnaround bits and 16 data bits, MSB first. On a read, the block drives 0 in the second turnaround bit, then the 16 data bits, then releases `mdio_oe`.
- R3: The implemented addresses are 0x00–0x06, 0x10, 0x11, 0x15, 0x1B, 0x1C, 0x1D and 0x1F. The storage registers read back what was last written. Addresses 0x02 and 0x03 always read the identifier words `ID_HI` and `ID_LO`, and writes to them are ignored. Unimplemented addresses read 0, and writes to them are ignored.
- R4: A read of 0x1B returns the enables in bits 15:8 and the condition flags in bits 7:0. The same read clears the flags.
- R5: An event pulse on bit n sets condition flag n whether or not enable n is set. A pulse in the cycle the flags are cleared leaves its flag set.
- R6: The interrupt is active while any flag is set together with its enable. Bit 9 of 0x1F selects the pin polarity: 0 makes the pin active low, 1 makes it active high.
- R7: A write to 0x1B loads only the enable byte, from data bits 15:8. The condition flags are left unchanged.
- R8: After reset, every storage register and the interrupt register read 0, `mdio_oe` is 0, and `intr_pin` is 1 (idle in active-low mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_addr_strap | input | 5 | PHY address strap |
| mdc | input | 1 | Management clock from the station manager |
| mdio_in | input | 1 | Management data, received value |
| mdio_out | output | 1 | Management data, driven value |
| mdio_oe | output | 1 | Output enable for `mdio_out` |
| evt_pulse | input | 8 | Single-cycle event pulses from the PHY core |
| intr_pin | output | 1 | Interrupt pin, polarity set by 0x1F bit 9 |

## Verification
The bench reads the interrupt register while holding an event across the clear cycle. A design that cleared unconditionally would lose that event, so the next read would show the flag missing. It pulses disabled events and expects the flag to latch while the pin stays idle; tying latching to the enables would drop the flag. It flips the polarity bit and checks both pin levels. It writes 0x1B with ones in the low byte, so a design that let the low byte reach the flags would show them set. It also sends frames to a foreign PHY address and to unimplemented or read-only addresses. A design that decoded the address loosely would then drive MDIO or corrupt stored words.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
   typedef enum logic [2:0] {
      FS_PRE, FS_ST, FS_OP, FS_ADR, FS_TA, FS_RD, FS_WR
   } frame_st_e;

   localparam logic [1:0] OP_RD = 2'b10;
   localparam logic [1:0] OP_WR = 2'b01;
endpackage

// File: rtl/mdio_frame.sv
module mdio_frame
   import phy_mgmt_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int AW          = 5,
   parameter int PRE_LEN     = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mdc,
   input  logic              mdio_in,
   input  logic [AW-1:0]     phy_addr,
   input  logic [DATA_W-1:0] rd_data,
   output logic              rd_req,
   output logic              wr_req,
   output logic [AW-1:0]     reg_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              mdio_out,
   output logic              mdio_oe
);
   localparam int CNT_MAX = (PRE_LEN > DATA_W) ? PRE_LEN : DATA_W;
   localparam int CW      = $clog2(CNT_MAX + 1);
   localparam int FW      = 2 * AW;

   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end

   logic [SYNC_STAGES:0] mdc_chain, dat_chain;
   logic                 mdc_prev, rise, bit_s;

   assign mdc_chain[0] = mdc;
   assign dat_chain[0] = mdio_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mdc_chain[SYNC_STAGES:1] <= '0;
         dat_chain[SYNC_STAGES:1] <= '1;
         mdc_prev                 <= 1'b0;
      end else begin
         mdc_chain[SYNC_STAGES:1] <= mdc_chain[SYNC_STAGES-1:0];
         dat_chain[SYNC_STAGES:1] <= dat_chain[SYNC_STAGES-1:0];
         mdc_prev                 <= mdc_chain[SYNC_STAGES];
      end
   end

   assign rise  = mdc_chain[SYNC_STAGES] & ~mdc_prev;
   assign bit_s = dat_chain[SYNC_STAGES];

   frame_st_e         st;
   logic [CW-1:0]     cnt;
   logic [1:0]        op_q;
   logic [FW-1:0]     adr_q;
   logic [FW-1:0]     adr_nxt;
   logic [DATA_W-1:0] sh_q;

   assign adr_nxt  = {adr_q[FW-2:0], bit_s};
   assign reg_addr = adr_q[AW-1:0];
   assign wr_data  = sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= FS_PRE;
         cnt      <= '0;
         op_q     <= '0;
         adr_q    <= '0;
         sh_q     <= '0;
         rd_req   <= 1'b0;
         wr_req   <= 1'b0;
         mdio_out <= 1'b0;
         mdio_oe  <= 1'b0;
      end else begin
         rd_req <= 1'b0;
         wr_req <= 1'b0;
         if (rd_req) sh_q <= rd_data;
         if (rise) begin
            unique case (st)
               FS_PRE: begin
                  if (bit_s) begin
                     if (cnt != CW'(PRE_LEN)) cnt <= cnt + 1'b1;
                  end else if (cnt == CW'(PRE_LEN)) begin
                     st <= FS_ST;
                  end else begin
                     cnt <= '0;
                  end
               end
               FS_ST: begin
                  cnt <= '0;
                  st  <= bit_s ? FS_OP : FS_PRE;
               end
               FS_OP: begin
                  op_q <= {op_q[0], bit_s};
                  if (cnt == CW'(1)) begin
                     cnt <= '0;
                     st  <= FS_ADR;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               FS_ADR: begin
                  adr_q <= adr_nxt;
                  if (cnt == CW'(FW - 1)) begin
                     cnt <= '0;
                     if (adr_nxt[FW-1:AW] == phy_addr &&
                         (op_q == OP_RD || op_q == OP_WR)) begin
                        st     <= FS_TA;
                        rd_req <= (op_q == OP_RD);
                     end else begin
                        st <= FS_PRE;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               FS_TA: begin
                  if (op_q == OP_RD) begin
                     mdio_oe  <= 1'b1;
                     mdio_out <= 1'b0;
                     cnt      <= '0;
                     st       <= FS_RD;
                  end else if (cnt == CW'(1)) begin
                     cnt <= '0;
                     st  <= FS_WR;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               FS_RD: begin
                  if (cnt == CW'(DATA_W)) begin
                     mdio_oe <= 1'b0;
                     cnt     <= '0;
                     st      <= FS_PRE;
                  end else begin
                     mdio_out <= sh_q[DATA_W-1];
                     sh_q     <= {sh_q[DATA_W-2:0], 1'b0};
                     cnt      <= cnt + 1'b1;
                  end
               end
               FS_WR: begin
                  sh_q <= {sh_q[DATA_W-2:0], bit_s};
                  if (cnt == CW'(DATA_W - 1)) begin
                     wr_req <= 1'b1;
                     cnt    <= '0;
                     st     <= FS_PRE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: st <= FS_PRE;
            endcase
         end
      end
   end
endmodule

// File: rtl/mgmt_regfile.sv
module mgmt_regfile #(
   parameter int          DATA_W    = 16,
   parameter int          AW        = 5,
   parameter logic [31:0] IMPL_MASK = 32'hB823_007F,
   parameter logic [15:0] ID_HI     = 16'h0A5C,
   parameter logic [15:0] ID_LO     = 16'h3E41,
   parameter int          INT_ADDR  = 27,
   parameter int          CTRL_ADDR = 31,
   parameter int          POL_BIT   = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic              rd_req,
   input  logic [AW-1:0]     reg_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] irq_word,
   output logic [DATA_W-1:0] rd_data,
   output logic              int_wr,
   output logic              int_rd,
   output logic              pin_pol
);
   localparam int NREG = 1 << AW;

   logic [NREG-1:0][DATA_W-1:0] word;

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (!IMPL_MASK[i]) begin : g_hole
         assign word[i] = '0;
      end else if (i == 2) begin : g_id_hi
         assign word[i] = DATA_W'(ID_HI);
      end else if (i == 3) begin : g_id_lo
         assign word[i] = DATA_W'(ID_LO);
      end else if (i == INT_ADDR) begin : g_irq
         assign word[i] = irq_word;
      end else begin : g_store
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  q <= '0;
            else if (wr_req && reg_addr == AW'(i))       q <= wr_data;
         end
         assign word[i] = q;
      end
   end

   assign rd_data = word[reg_addr];
   assign int_wr  = wr_req && (reg_addr == AW'(INT_ADDR));
   assign int_rd  = rd_req && (reg_addr == AW'(INT_ADDR));
   assign pin_pol = word[CTRL_ADDR][POL_BIT];
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
   parameter int EVT_W   = 8,
   parameter bit REG_PIN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [EVT_W-1:0]   evt,
   input  logic               en_wr,
   input  logic [EVT_W-1:0]   en_data,
   input  logic               rd_clr,
   input  logic               active_hi,
   output logic [EVT_W-1:0]   en_q,
   output logic [EVT_W-1:0]   cond_q,
   output logic               intr_pin
);
   logic active, pin_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         cond_q <= '0;
      end else begin
         if (en_wr) en_q <= en_data;
         cond_q <= rd_clr ? evt : (cond_q | evt);
      end
   end

   assign active = |(en_q & cond_q);
   assign pin_d  = active_hi ? active : ~active;

   if (REG_PIN) begin : g_reg_pin
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) intr_pin <= 1'b1;
         else        intr_pin <= pin_d;
      end
   end else begin : g_comb_pin
      assign intr_pin = pin_d;
   end
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
   import phy_mgmt_pkg::*;
#(
   parameter int          DATA_W      = 16,
   parameter int          AW          = 5,
   parameter int          EVT_W       = 8,
   parameter int          PRE_LEN     = 32,
   parameter int          SYNC_STAGES = 2,
   parameter int          NUM_REGS    = 14,
   parameter logic [31:0] IMPL_MASK   = 32'hB823_007F,
   parameter logic [15:0] ID_HI       = 16'h0A5C,
   parameter logic [15:0] ID_LO       = 16'h3E41,
   parameter int          INT_ADDR    = 27,
   parameter int          CTRL_ADDR   = 31,
   parameter int          POL_BIT     = 9,
   parameter bit          REG_PIN     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    phy_addr_strap,
   input  logic             mdc,
   input  logic             mdio_in,
   output logic             mdio_out,
   output logic             mdio_oe,
   input  logic [EVT_W-1:0] evt_pulse,
   output logic             intr_pin
);
   if (2 * EVT_W != DATA_W) begin : g_bad_evt
      $error("EVT_W must be half of DATA_W");
   end
   if (AW != 5) begin : g_bad_aw
      $error("Clause 22 framing needs 5-bit address fields");
   end
   if ($countones(IMPL_MASK) != NUM_REGS) begin : g_bad_mask
      $error("IMPL_MASK does not match NUM_REGS");
   end
   if (!IMPL_MASK[INT_ADDR] || !IMPL_MASK[CTRL_ADDR]) begin : g_bad_map
      $error("interrupt and control registers must be implemented");
   end
   if (POL_BIT >= DATA_W) begin : g_bad_pol
      $error("POL_BIT out of range");
   end

   logic              rd_req, wr_req, int_wr, int_rd, pin_pol;
   logic [AW-1:0]     reg_addr;
   logic [DATA_W-1:0] wr_data, rd_data;
   logic [EVT_W-1:0]  irq_en, irq_cond;

   mdio_frame #(
      .DATA_W(DATA_W), .AW(AW), .PRE_LEN(PRE_LEN), .SYNC_STAGES(SYNC_STAGES)
   ) u_frame (
      .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_in(mdio_in),
      .phy_addr(phy_addr_strap), .rd_data(rd_data),
      .rd_req(rd_req), .wr_req(wr_req), .reg_addr(reg_addr),
      .wr_data(wr_data), .mdio_out(mdio_out), .mdio_oe(mdio_oe)
   );

   mgmt_regfile #(
      .DATA_W(DATA_W), .AW(AW), .IMPL_MASK(IMPL_MASK), .ID_HI(ID_HI),
      .ID_LO(ID_LO), .INT_ADDR(INT_ADDR), .CTRL_ADDR(CTRL_ADDR),
      .POL_BIT(POL_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req),
      .reg_addr(reg_addr), .wr_data(wr_data),
      .irq_word({irq_en, irq_cond}), .rd_data(rd_data),
      .int_wr(int_wr), .int_rd(int_rd), .pin_pol(pin_pol)
   );

   irq_ctrl #(
      .EVT_W(EVT_W), .REG_PIN(REG_PIN)
   ) u_irq (
      .clk(clk), .rst_n(rst_n), .evt(evt_pulse), .en_wr(int_wr),
      .en_data(wr_data[DATA_W-1:EVT_W]), .rd_clr(int_rd),
      .active_hi(pin_pol), .en_q(irq_en), .cond_q(irq_cond),
      .intr_pin(intr_pin)
   );
endmodule

// File: rtl/phy_mgmt_chk.sv
module phy_mgmt_chk #(
   parameter int EVT_W   = 8,
   parameter bit REG_PIN = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [EVT_W-1:0] evt,
   input logic [EVT_W-1:0] cond,
   input logic [EVT_W-1:0] en,
   input logic             rd_clr,
   input logic             en_wr,
   input logic             pol,
   input logic             intr_pin
);
   // R5: every pulsed event is latched in the next cycle
   p_evt_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != '0) |=> ((cond & $past(evt)) == $past(evt)));

   // R4: clearing read leaves only events of that cycle
   p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_clr |=> (cond == $past(evt)));

   // R7: writing the interrupt register never disturbs the flags
   p_wr_keeps_cond_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en_wr && !rd_clr) |=> (cond == ($past(cond) | $past(evt))));

   // R6: pin idle level follows polarity
   p_pin_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (REG_PIN && (en & cond) == '0) |=> (intr_pin == !$past(pol)));

   // R6: pin active level follows polarity
   p_pin_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (REG_PIN && (en & cond) != '0) |=> (intr_pin == $past(pol)));
endmodule

bind phy_mgmt_regs phy_mgmt_chk #(.EVT_W(EVT_W), .REG_PIN(REG_PIN)) u_chk (
   .clk(clk), .rst_n(rst_n), .evt(evt_pulse), .cond(irq_cond), .en(irq_en),
   .rd_clr(int_rd), .en_wr(int_wr), .pol(pin_pol), .intr_pin(intr_pin)
);

// File: tb/test_phy_mgmt_regs.sv
module test_phy_mgmt_regs;
   localparam logic [4:0]  MY_PHY = 5'd13;
   localparam logic [15:0] ID_HI  = 16'h0A5C;
   localparam logic [15:0] ID_LO  = 16'h3E41;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mdc = 1'b0;
   logic       mdio_drv = 1'b1;
   logic [7:0] evt = '0;
   logic       mdio_out, mdio_oe, intr_pin;

   int n_chk = 0;
   int n_bad = 0;
   bit oe_seen;

   logic [15:0] exp_q[$];
   string       tag_q[$];

   always #4 clk = ~clk;

   phy_mgmt_regs i_phy_mgmt_regs (
      .clk(clk), .rst_n(rst_n), .phy_addr_strap(MY_PHY), .mdc(mdc),
      .mdio_in(mdio_drv), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
      .evt_pulse(evt), .intr_pin(intr_pin)
   );

   task automatic chk(input bit ok, input string req, input logic [15:0] act,
                      input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   always @(posedge clk) if (mdio_oe) oe_seen = 1'b1;

   // monitor: collects read data at each falling MDC edge
   int          mon = 0;
   logic [15:0] mon_data;
   always @(negedge mdc) begin
      if (mon == 0) begin
         if (mdio_oe) begin
            chk(mdio_out == 1'b0, "R2 turnaround", {15'd0, mdio_out}, 16'd0);
            mon      = 1;
            mon_data = '0;
         end
      end else begin
         mon_data = {mon_data[14:0], mdio_out};
         mon++;
         if (mon == 17) begin
            mon = 0;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R1 unexpected read response", mon_data, 16'd0);
            end else begin
               logic [15:0] e;
               string       t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(mon_data == e, t, mon_data, e);
            end
         end
      end
   end

   task automatic mbit(input logic b, input logic [7:0] ev = 8'h00);
      @(negedge clk);
      mdio_drv = b;
      mdc      = 1'b0;
      repeat (4) @(negedge clk);
      mdc = 1'b1;
      evt = ev;
      repeat (4) @(negedge clk);
      evt = '0;
   endtask

   task automatic header(input logic [1:0] op, input logic [4:0] phy,
                         input logic [4:0] ra, input logic [7:0] ev_last);
      for (int i = 0; i < 32; i++) mbit(1'b1);
      mbit(1'b0); mbit(1'b1);
      mbit(op[1]); mbit(op[0]);
      for (int i = 4; i >= 0; i--) mbit(phy[i]);
      for (int i = 4; i > 0; i--) mbit(ra[i]);
      mbit(ra[0], ev_last);
   endtask

   task automatic mwrite(input logic [4:0] phy, input logic [4:0] ra,
                         input logic [15:0] d);
      header(2'b01, phy, ra, 8'h00);
      mbit(1'b1); mbit(1'b0);
      for (int i = 15; i >= 0; i--) mbit(d[i]);
      mbit(1'b1);
      repeat (4) @(negedge clk);
   endtask

   task automatic mread(input logic [4:0] ra, input logic [15:0] e,
                        input string tag, input logic [7:0] ev_last = 8'h00);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      header(2'b10, MY_PHY, ra, ev_last);
      for (int i = 0; i < 19; i++) mbit(1'b1);
      repeat (4) @(negedge clk);
      chk(mdio_oe == 1'b0, "R2 release", {15'd0, mdio_oe}, 16'd0);
   endtask

   task automatic pulse(input logic [7:0] m);
      @(negedge clk); evt = m;
      @(negedge clk); evt = '0;
      repeat (3) @(negedge clk);
   endtask

   task automatic pin_is(input logic v, input string tag);
      chk(intr_pin == v, tag, {15'd0, intr_pin}, {15'd0, v});
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog", 16'd0, 16'd1);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      pin_is(1'b1, "R8 pin idle after reset");
      chk(mdio_oe == 1'b0, "R8 oe after reset", {15'd0, mdio_oe}, 16'd0);

      mread(5'h00, 16'h0000, "R8 reg0 reset");
      mread(5'h1B, 16'h0000, "R8 interrupt reg reset");
      mread(5'h02, ID_HI, "R3 id high");
      mread(5'h03, ID_LO, "R3 id low");

      mwrite(MY_PHY, 5'h00, 16'h1234);
      mread(5'h00, 16'h1234, "R3 reg0 readback");
      mwrite(MY_PHY, 5'h1D, 16'hBEEF);
      mread(5'h1D, 16'hBEEF, "R3 reg1D readback");
      mwrite(MY_PHY, 5'h02, 16'hFFFF);
      mread(5'h02, ID_HI, "R3 id write ignored");
      mwrite(MY_PHY, 5'h08, 16'hFFFF);
      mread(5'h08, 16'h0000, "R3 hole reads zero");

      mwrite(5'd14, 5'h00, 16'h5555);
      mread(5'h00, 16'h1234, "R1 foreign write ignored");
      oe_seen = 1'b0;
      header(2'b10, 5'd14, 5'h00, 8'h00);
      for (int i = 0; i < 19; i++) mbit(1'b1);
      chk(!oe_seen, "R1 foreign read silent", {15'd0, oe_seen}, 16'd0);

      pulse(8'h08);
      pin_is(1'b1, "R6 disabled event keeps pin idle");
      mread(5'h1B, 16'h0008, "R5 disabled flag latched");
      mread(5'h1B, 16'h0000, "R4 flags cleared by read");

      mwrite(MY_PHY, 5'h1B, 16'hA5FF);
      mread(5'h1B, 16'hA500, "R7 write loads enables only");
      pin_is(1'b1, "R7 pin idle after enable write");

      pulse(8'h01);
      pin_is(1'b0, "R6 active low assert");
      mread(5'h1B, 16'hA501, "R4 read flags");
      pin_is(1'b1, "R4 pin released by read");

      pulse(8'h02);
      pin_is(1'b1, "R6 masked bit");
      mread(5'h1B, 16'hA502, "R5 masked flag");

      mwrite(MY_PHY, 5'h1F, 16'h0200);
      pin_is(1'b0, "R6 active high idle");
      pulse(8'h04);
      pin_is(1'b1, "R6 active high assert");
      mread(5'h1B, 16'hA504, "R4 read flags hi");
      pin_is(1'b0, "R6 active high release");

      mread(5'h1B, 16'hA580, "R5 event around clear", 8'h80);
      repeat (3) @(negedge clk);
      pin_is(1'b1, "R5 event kept through clear");
      mread(5'h1B, 16'hA580, "R5 kept flag reads back");
      pin_is(1'b0, "R4 pin release after second read");

      repeat (20) @(negedge clk);
      chk(exp_q.size() == 0, "R2 all reads answered",
          16'(exp_q.size()), 16'd0);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule